// File: doc/BRIEF.md
# Inverter Input Current Estimator

This block derives the dc-side current drawn by a two-level three-phase bridge without a sensor on the dc bus. It takes two signed phase-current samples and the on/off pattern of the three upper switches. From these it selects the phase current that the bridge routes onto the dc bus and gives it the right sign. The third phase current is rebuilt from the two sampled ones.

Each sampling period it gives two results from one sample set. The first is the estimate for the switch pattern now applied. The second is a one-step-ahead prediction for the pattern the modulator will apply next. Both results are registered together and carry a one-cycle valid pulse. Downstream timing arithmetic can then use the present value and the predicted one.

Top module: `icur_est_top`

## Requirements
- R1: The switch pattern is 3 bits {A,B,C}, with bit 2 for phase A and bit 0 for phase C, where 1 means the upper switch is on. 3'b100 gives +iA, 3'b011 gives -iA, 3'b010 gives +iB, 3'b101 gives -iB, 3'b001 gives +iC and 3'b110 gives -iC.
- R2: The third phase current is iC = -(iA + iB), formed with enough headroom that no intermediate sum wraps.
- R3: The patterns 3'b000 and 3'b111 give an estimate of exactly 0.
- R4: est_now is taken from sw_now and est_next from sw_next, both from the same strobed samples. Equal patterns give equal results.
- R5: A result outside the signed OW-bit range is clamped to the nearest limit, 2^(OW-1)-1 or -2^(OW-1), and never wraps.
- R6: After a strobe at a clock edge, both outputs and est_vld update at that edge. est_vld is high for exactly that one cycle per strobe.
- R7: Without a strobe, est_now and est_next keep their values whatever the inputs do.
- R8: After reset, est_now and est_next are 0 and est_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe; captures a new pair of estimates |
| ia_smp | input | SW (12) | Phase A current sample, signed |
| ib_smp | input | SW (12) | Phase B current sample, signed |
| sw_now | input | 3 | Upper-switch pattern applied now {A,B,C} |
| sw_next | input | 3 | Upper-switch pattern to be applied next {A,B,C} |
| est_now | output | OW (14) | Estimate for the present pattern, signed |
| est_next | output | OW (14) | Predicted estimate for the next pattern, signed |
| est_vld | output | 1 | One-cycle pulse marking fresh estimates |

## Verification
The present-state selection and the next-state prediction are computed in the same cycle from one sample set. The sweep drives every one of the 64 ordered pairs of sw_now and sw_next against sample pairs that include both extremes. A mix-up between the two selector lanes, or a lane reading the wrong pattern, therefore shows up on one of the outputs. A second instance with a narrow output width makes clamping coincide with reconstruction of the third phase. Both outputs are compared with integer arithmetic computed in the bench.

// File: rtl/icur_est_pkg.sv
package icur_est_pkg;

  typedef enum logic [1:0] {
    LEG_NONE = 2'd0,
    LEG_A    = 2'd1,
    LEG_B    = 2'd2,
    LEG_C    = 2'd3
  } leg_e;

  typedef struct packed {
    leg_e leg;
    logic neg;
  } leg_pick_t;

  // Upper-switch pattern {A,B,C} -> which phase is on the dc bus and its sign
  function automatic leg_pick_t decode_pattern(input logic [2:0] sw);
    leg_pick_t p;
    p.leg = LEG_NONE;
    p.neg = 1'b0;
    case (sw)
      3'b100: begin p.leg = LEG_A; p.neg = 1'b0; end
      3'b011: begin p.leg = LEG_A; p.neg = 1'b1; end
      3'b010: begin p.leg = LEG_B; p.neg = 1'b0; end
      3'b101: begin p.leg = LEG_B; p.neg = 1'b1; end
      3'b001: begin p.leg = LEG_C; p.neg = 1'b0; end
      3'b110: begin p.leg = LEG_C; p.neg = 1'b1; end
      default: begin p.leg = LEG_NONE; p.neg = 1'b0; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/icur_phase_rebuild.sv
module icur_phase_rebuild #(
  parameter int SW = 12,
  localparam int XW = SW + 2
) (
  input  logic signed [SW-1:0] ia_smp,
  input  logic signed [SW-1:0] ib_smp,
  output logic signed [XW-1:0] ia_x,
  output logic signed [XW-1:0] ib_x,
  output logic signed [XW-1:0] ic_x
);

  logic signed [XW-1:0] sum_ab;

  always_comb begin
    ia_x   = XW'(ia_smp);
    ib_x   = XW'(ib_smp);
    sum_ab = ia_x + ib_x;
    ic_x   = -sum_ab;
  end

endmodule

// File: rtl/icur_leg_select.sv
module icur_leg_select
  import icur_est_pkg::*;
#(
  parameter int SW = 12,
  parameter int OW = 14,
  localparam int XW = SW + 2,
  localparam int NW = XW + 1
) (
  input  logic [2:0]           sw,
  input  logic signed [XW-1:0] ia_x,
  input  logic signed [XW-1:0] ib_x,
  input  logic signed [XW-1:0] ic_x,
  output leg_e                 leg,
  output logic signed [OW-1:0] est
);

  localparam logic signed [NW-1:0] HI_W = NW'((2 ** (OW - 1)) - 1);
  localparam logic signed [NW-1:0] LO_W = -HI_W - NW'(1);

  function automatic logic signed [OW-1:0] clamp_out(input logic signed [NW-1:0] v);
    if (v > HI_W)      return HI_W[OW-1:0];
    else if (v < LO_W) return LO_W[OW-1:0];
    else               return v[OW-1:0];
  endfunction

  leg_pick_t            pick;
  logic signed [XW-1:0] base;
  logic signed [NW-1:0] ext;
  logic signed [NW-1:0] signed_val;

  always_comb begin
    pick = decode_pattern(sw);
    leg  = pick.leg;
    case (pick.leg)
      LEG_A:   base = ia_x;
      LEG_B:   base = ib_x;
      LEG_C:   base = ic_x;
      default: base = '0;
    endcase
    ext        = NW'(base);
    signed_val = pick.neg ? -ext : ext;
    est        = clamp_out(signed_val);
  end

endmodule

// File: rtl/icur_est_top.sv
module icur_est_top
  import icur_est_pkg::*;
#(
  parameter int SW = 12,
  parameter int OW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [SW-1:0] ia_smp,
  input  logic signed [SW-1:0] ib_smp,
  input  logic [2:0]           sw_now,
  input  logic [2:0]           sw_next,
  output logic signed [OW-1:0] est_now,
  output logic signed [OW-1:0] est_next,
  output logic                 est_vld
);

  localparam int XW    = SW + 2;
  localparam int LANES = 2;

  logic signed [XW-1:0] ia_x, ib_x, ic_x;
  logic [2:0]           lane_sw  [LANES];
  logic signed [OW-1:0] lane_est [LANES];
  leg_e                 lane_leg [LANES];

  assign lane_sw[0] = sw_now;
  assign lane_sw[1] = sw_next;

  icur_phase_rebuild #(.SW(SW)) u_rebuild (
    .ia_smp (ia_smp),
    .ib_smp (ib_smp),
    .ia_x   (ia_x),
    .ib_x   (ib_x),
    .ic_x   (ic_x)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    icur_leg_select #(.SW(SW), .OW(OW)) u_sel (
      .sw   (lane_sw[g]),
      .ia_x (ia_x),
      .ib_x (ib_x),
      .ic_x (ic_x),
      .leg  (lane_leg[g]),
      .est  (lane_est[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_now  <= '0;
      est_next <= '0;
      est_vld  <= 1'b0;
    end else begin
      est_vld <= smp_stb;
      if (smp_stb) begin
        est_now  <= lane_est[0];
        est_next <= lane_est[1];
      end
    end
  end

endmodule

// File: rtl/icur_est_chk.sv
module icur_est_chk #(
  parameter int SW = 12,
  parameter int OW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic signed [SW-1:0] ia_smp,
  input logic [2:0]           sw_now,
  input logic [2:0]           sw_next,
  input logic signed [OW-1:0] est_now,
  input logic signed [OW-1:0] est_next,
  input logic                 est_vld
);

  wire zero_now  = (sw_now == 3'b000) || (sw_now == 3'b111);
  wire same_pat  = (sw_now == sw_next);
  wire a_pos_now = (sw_now == 3'b100) && (ia_smp > 0);

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> est_vld);
  p_vld_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !est_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(est_now) && $stable(est_next)));
  p_zero_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && zero_now) |=> (est_now == '0));
  p_lanes_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && same_pat) |=> (est_now == est_next));
  p_sign_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && a_pos_now) |=> (est_now > 0));

endmodule

bind icur_est_top icur_est_chk #(.SW(SW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_stb  (smp_stb),
  .ia_smp   (ia_smp),
  .sw_now   (sw_now),
  .sw_next  (sw_next),
  .est_now  (est_now),
  .est_next (est_next),
  .est_vld  (est_vld)
);

// File: tb/icur_est_top_bench.sv
`timescale 1ns/1ps
module icur_est_top_bench;

  localparam int SW  = 12;
  localparam int OW  = 14;
  localparam int OWN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [SW-1:0] ia_smp = '0, ib_smp = '0;
  logic [2:0] sw_now = '0, sw_next = '0;
  logic signed [OW-1:0]  est_now, est_next;
  logic signed [OWN-1:0] nr_now, nr_next;
  logic est_vld, nr_vld;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  icur_est_top #(.SW(SW), .OW(OW)) u_icur_est_top (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ia_smp(ia_smp), .ib_smp(ib_smp),
    .sw_now(sw_now), .sw_next(sw_next), .est_now(est_now), .est_next(est_next),
    .est_vld(est_vld));

  icur_est_top #(.SW(SW), .OW(OWN)) u_icur_est_top_narrow (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ia_smp(ia_smp), .ib_smp(ib_smp),
    .sw_now(sw_now), .sw_next(sw_next), .est_now(nr_now), .est_next(nr_next),
    .est_vld(nr_vld));

  function automatic int model(input int a, input int b, input int s, input int w);
    int c, r, hi, lo;
    c = 0 - a - b;
    case (s)
      4: r = a;   3: r = -a;
      2: r = b;   5: r = -b;
      1: r = c;   6: r = -c;
      default: r = 0;
    endcase
    hi = (1 <<< (w - 1)) - 1;
    lo = -(1 <<< (w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int sn, input int sx);
    int en, ex, nn, nx, old_now, old_next, old_nn;
    en = model(a, b, sn, OW);   ex = model(a, b, sx, OW);
    nn = model(a, b, sn, OWN);  nx = model(a, b, sx, OWN);
    @(negedge clk);
    ia_smp = SW'(a); ib_smp = SW'(b); sw_now = 3'(sn); sw_next = 3'(sx);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    check("R6 valid pulse", int'(est_vld), 1);
    check((sn == 0 || sn == 7) ? "R3 zero now" : "R1/R2 now", int'(est_now), en);
    check("R4 next lane", int'(est_next), ex);
    check("R5 narrow now", int'(nr_now), nn);
    check("R5 narrow next", int'(nr_next), nx);
    old_now = int'(est_now); old_next = int'(est_next); old_nn = int'(nr_now);
    ia_smp = ~ia_smp; ib_smp = ib_smp + 12'sd5; sw_now = ~sw_now; sw_next = sw_next + 3'd1;
    @(negedge clk);
    check("R6 valid single", int'(est_vld), 0);
    check("R7 hold now", int'(est_now), old_now);
    check("R7 hold next", int'(est_next), old_next);
    check("R7 hold narrow", int'(nr_now), old_nn);
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pa [7] = '{0, 100, 2047, -2048, -2048, 1, 2047};
    int pb [7] = '{0, -37, 2047, -2048, 2047, -300, -2048};
    repeat (3) @(negedge clk);
    check("R8 reset vld", int'(est_vld), 0);
    check("R8 reset now", int'(est_now), 0);
    check("R8 reset next", int'(est_next), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 post reset vld", int'(est_vld), 0);
    check("R8 post reset now", int'(est_now), 0);
    for (int p = 0; p < 7; p++)
      for (int sn = 0; sn < 8; sn++)
        for (int sx = 0; sx < 8; sx++)
          apply(pa[p], pb[p], sn, sx);
    // R5 explicit corner: -iA with iA at most negative, narrow width clamps
    apply(-2048, 0, 3, 6);
    check("R5 clamp corner", int'(nr_now), 2047);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule